// File: doc/BRIEF.md
# Multi-View Hardware FIFO Cell

This block is one inter-thread communication cell that holds a small hardware queue and sits behind a load/store port. Every request carries a view select, a read/write flag, write data and the issuing thread's ID. The view decides how the request treats the one shared queue. The synchronized view pushes and pops, and it parks a thread whose request cannot proceed. The try view pushes and pops but never parks a thread. The bypass view peeks at the oldest entry or patches the newest one without touching occupancy. The control view reads or writes a small tag word.

A parked request is not retried by the requester. The cell keeps the parked operation, together with its store data, in a per-thread slot and marks the thread in a blocked bitmap. When the blocking condition goes away, the cell completes the operation on its own and reports the completion on a separate release channel. Every request gets a response one cycle later that says either "done, here is the read data" or "blocked".

Occupancy is tracked by a three-state machine. The states are OCC_EMPTY, OCC_PART and OCC_FULL. OCC_EMPTY goes to OCC_PART on a push, or to OCC_FULL on a push when the depth is 1. OCC_PART goes to OCC_FULL when a push without a pop fills the last slot. OCC_PART goes to OCC_EMPTY when a pop without a push takes the last entry, or on a flush. OCC_FULL goes to OCC_PART on a pop without a push, or to OCC_EMPTY when the depth is 1. OCC_FULL goes to OCC_EMPTY on a flush.

Top module: `xview_fifo_cell`

## Requirements
- R1: After reset the cell is empty and no thread is blocked. A control-view read returns 0x5.
- R2: Synchronized-view and try-view stores append to the queue, and loads from these views return entries oldest first and remove them.
- R3: Some synchronized-view requests block: a load on an empty cell, or a store on a full cell. Such a request gets a response with `rsp_blocked`=1. The bit of the requesting thread is then set in `blocked_map`, and the operation and its store data are kept.
- R4: A blocked operation completes in the first cycle in which its condition is clear. The following happens in the cycle after that: `rel_valid` pulses with the thread ID, and `rel_rdata` holds the popped value for a load or 0 for a store. The thread's bit in `blocked_map` is cleared.
- R5: When several blocked threads could complete, only the lowest thread index completes in a cycle.
- R6: Try-view requests never block. A try store on a full cell is dropped, and a try load on an empty cell returns 0.
- R7: A bypass-view load returns the oldest entry without removing it, and returns 0 on an empty cell.
- R8: A bypass-view store replaces the newest entry without changing occupancy, and a bypass-view store on an empty cell is dropped.
- R9: The tag word read in the control view has Empty in bit 0 and Full in bit 1. Bit 2 reads as 1 and marks the cell as a queue. All other bits read as 0.
- R10: A control-view store with bit 0 set empties the queue. Bits 1 and 2 of that store, and any store with bit 0 clear, change nothing.
- R11: A new request and a completing blocked operation can be a push and a pop in the same cycle, on a cell that is neither empty nor full. Both then take effect and the occupancy stays the same.
- R12: Full is reported exactly when the count equals `DEPTH`, and Empty is reported exactly when the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_view | input | 2 | View: 0 synchronized, 1 try, 2 bypass, 3 control |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | DW | Store data |
| req_tid | input | TIDW | Issuing thread |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_blocked | output | 1 | Previous request was parked |
| rsp_rdata | output | DW | Load data of the previous request (0 for stores) |
| rel_valid | output | 1 | A parked operation completed |
| rel_tid | output | TIDW | Thread whose operation completed |
| rel_rdata | output | DW | Popped data for a parked load, 0 for a parked store |
| blocked_map | output | NTHREADS | One bit per thread that is currently parked |

## Verification
The bench uses the default build: a depth of 4, 32-bit entries and 4 threads. With a depth of 4, the full state is reached after four stores, so blocked stores, dropped try stores and the full flag can all be exercised in a few cycles. With four threads, two loads can be parked at once and the lowest-index release order can be observed. A parked load can also be released in the same cycle as a fresh store, which shows a push and a pop that leave the occupancy unchanged.

// File: rtl/xvc_pkg.sv
package xvc_pkg;
    typedef enum logic [1:0] {
        VW_SYNC = 2'd0,
        VW_TRY  = 2'd1,
        VW_BYP  = 2'd2,
        VW_CTRL = 2'd3
    } view_e;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;

    localparam int TAG_EMPTY_BIT = 0;
    localparam int TAG_FULL_BIT  = 1;
    localparam int TAG_KIND_BIT  = 2;
endpackage

// File: rtl/xvc_queue.sv
module xvc_queue
    import xvc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          ovr,
    input  logic [DW-1:0] ovr_data,
    input  logic          flush,
    output logic [DW-1:0] head_data,
    output logic          is_empty,
    output logic          is_full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] slots [DEPTH];
    logic [PW-1:0] head_q, tail_q, newest;
    logic [CW-1:0] count_q;
    occ_e          state_q, state_nx;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign newest    = (tail_q == '0) ? LAST : tail_q - 1'b1;
    assign head_data = slots[head_q];

    always_ff @(posedge clk) begin
        if (push)
            slots[tail_q] <= push_data;
        else if (ovr)
            slots[newest] <= ovr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (flush) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= bump(tail_q);
            if (pop)  head_q <= bump(head_q);
            if (push && !pop)      count_q <= count_q + 1'b1;
            else if (pop && !push) count_q <= count_q - 1'b1;
        end
    end

    // occupancy state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            OCC_EMPTY: if (push && !flush) state_nx = (DEPTH == 1) ? OCC_FULL : OCC_PART;
            OCC_PART: begin
                if (flush)
                    state_nx = OCC_EMPTY;
                else if (push && !pop && count_q == CW'(DEPTH - 1))
                    state_nx = OCC_FULL;
                else if (pop && !push && count_q == CW'(1))
                    state_nx = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (flush)
                    state_nx = OCC_EMPTY;
                else if (pop && !push)
                    state_nx = (DEPTH == 1) ? OCC_EMPTY : OCC_PART;
            end
            default: state_nx = OCC_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        is_empty = 1'b0;
        is_full  = 1'b0;
        unique case (state_q)
            OCC_EMPTY: is_empty = 1'b1;
            OCC_PART:  ;
            OCC_FULL:  is_full = 1'b1;
            default:   is_empty = 1'b1;
        endcase
    end

    a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !is_full);
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !is_empty);
    a_r12_flags_match_count: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty == (count_q == '0)) && (is_full == (count_q == CW'(DEPTH))));
    a_r11_push_pop_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush) |=> $stable(count_q));
endmodule

// File: rtl/xvc_waiters.sv
module xvc_waiters #(
    parameter int NT   = 4,
    parameter int DW   = 32,
    parameter int TIDW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cur_empty,
    input  logic            cur_full,
    input  logic            allow_rd,
    input  logic            allow_wr,
    input  logic            record,
    input  logic [TIDW-1:0] rec_tid,
    input  logic            rec_wr,
    input  logic [DW-1:0]   rec_data,
    output logic [NT-1:0]   blocked_map,
    output logic            wake_fire,
    output logic [TIDW-1:0] wake_tid,
    output logic            wake_wr,
    output logic [DW-1:0]   wake_data
);
    logic [NT-1:0] pend_wr;
    logic [DW-1:0] pend_data [NT];
    logic [NT-1:0] ready;

    for (genvar t = 0; t < NT; t++) begin : g_ready
        assign ready[t] = blocked_map[t] &&
                          (pend_wr[t] ? (!cur_full && allow_wr) : (!cur_empty && allow_rd));
    end

    always_comb begin
        wake_fire = 1'b0;
        wake_tid  = '0;
        for (int t = 0; t < NT; t++) begin
            if (!wake_fire && ready[t]) begin
                wake_fire = 1'b1;
                wake_tid  = TIDW'(t);
            end
        end
    end

    assign wake_wr   = pend_wr[wake_tid];
    assign wake_data = pend_data[wake_tid];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked_map <= '0;
            pend_wr     <= '0;
        end else begin
            if (wake_fire) blocked_map[wake_tid] <= 1'b0;
            if (record) begin
                blocked_map[rec_tid] <= 1'b1;
                pend_wr[rec_tid]     <= rec_wr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (record) pend_data[rec_tid] <= rec_data;
    end

    a_r3_no_double_park: assert property (@(posedge clk) disable iff (!rst_n)
        record |-> !blocked_map[rec_tid]);
    a_r4_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wake_fire |=> !blocked_map[$past(wake_tid)]);
    a_r5_release_parked_only: assert property (@(posedge clk) disable iff (!rst_n)
        wake_fire |-> blocked_map[wake_tid]);
endmodule

// File: rtl/xview_fifo_cell.sv
module xview_fifo_cell
    import xvc_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int DW       = 32,
    parameter int NTHREADS = 4,
    localparam int TIDW    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_view,
    input  logic                req_write,
    input  logic [DW-1:0]       req_wdata,
    input  logic [TIDW-1:0]     req_tid,
    output logic                rsp_valid,
    output logic                rsp_blocked,
    output logic [DW-1:0]       rsp_rdata,
    output logic                rel_valid,
    output logic [TIDW-1:0]     rel_tid,
    output logic [DW-1:0]       rel_rdata,
    output logic [NTHREADS-1:0] blocked_map
);
    view_e         view;
    logic          queued_view;
    logic          new_push, new_pop, new_block, byp_wr, do_flush;
    logic          allow_rd, allow_wr;
    logic          q_push, q_pop, is_empty, is_full;
    logic [DW-1:0] head_data, push_data, tag_word, rd_nx;
    logic          wake_fire, wake_wr;
    logic [TIDW-1:0] wake_tid;
    logic [DW-1:0] wake_data;

    assign view        = view_e'(req_view);
    assign queued_view = req_valid && (view == VW_SYNC || view == VW_TRY);
    assign new_push    = queued_view && req_write && !is_full;
    assign new_pop     = queued_view && !req_write && !is_empty;
    assign new_block   = req_valid && view == VW_SYNC && (req_write ? is_full : is_empty);
    assign byp_wr      = req_valid && view == VW_BYP && req_write && !is_empty;
    assign do_flush    = req_valid && view == VW_CTRL && req_write && req_wdata[TAG_EMPTY_BIT];

    // a parked op may run beside a new op only if it is of the other kind
    assign allow_wr = !byp_wr && !do_flush && !new_push;
    assign allow_rd = !byp_wr && !do_flush && !new_pop;

    assign q_push    = new_push || (wake_fire && wake_wr);
    assign q_pop     = new_pop  || (wake_fire && !wake_wr);
    assign push_data = new_push ? req_wdata : wake_data;

    always_comb begin
        tag_word                = '0;
        tag_word[TAG_EMPTY_BIT] = is_empty;
        tag_word[TAG_FULL_BIT]  = is_full;
        tag_word[TAG_KIND_BIT]  = 1'b1;
    end

    always_comb begin
        rd_nx = '0;
        if (req_valid && !req_write) begin
            unique case (view)
                VW_SYNC, VW_TRY: rd_nx = new_pop ? head_data : '0;
                VW_BYP:          rd_nx = is_empty ? '0 : head_data;
                VW_CTRL:         rd_nx = tag_word;
                default:         rd_nx = '0;
            endcase
        end
    end

    xvc_queue #(.DEPTH(DEPTH), .DW(DW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (push_data),
        .pop       (q_pop),
        .ovr       (byp_wr),
        .ovr_data  (req_wdata),
        .flush     (do_flush),
        .head_data (head_data),
        .is_empty  (is_empty),
        .is_full   (is_full)
    );

    xvc_waiters #(.NT(NTHREADS), .DW(DW), .TIDW(TIDW)) u_waiters (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_empty   (is_empty),
        .cur_full    (is_full),
        .allow_rd    (allow_rd),
        .allow_wr    (allow_wr),
        .record      (new_block),
        .rec_tid     (req_tid),
        .rec_wr      (req_write),
        .rec_data    (req_wdata),
        .blocked_map (blocked_map),
        .wake_fire   (wake_fire),
        .wake_tid    (wake_tid),
        .wake_wr     (wake_wr),
        .wake_data   (wake_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_blocked <= 1'b0;
            rsp_rdata   <= '0;
            rel_valid   <= 1'b0;
            rel_tid     <= '0;
            rel_rdata   <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_blocked <= new_block;
            rsp_rdata   <= rd_nx;
            rel_valid   <= wake_fire;
            rel_tid     <= wake_tid;
            rel_rdata   <= (wake_fire && !wake_wr) ? head_data : '0;
        end
    end

    a_r6_only_sync_parks: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_blocked |-> ($past(req_view) == VW_SYNC));
    a_r3_parked_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_blocked |-> blocked_map[$past(req_tid)]);
    a_r1_blocked_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_blocked |-> rsp_valid);
endmodule

// File: tb/xview_fifo_cell_bench.sv
module xview_fifo_cell_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] V_SYNC = 2'd0, V_TRY = 2'd1, V_BYP = 2'd2, V_CTRL = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_view = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_tid = '0;
    logic        rsp_valid, rsp_blocked, rel_valid;
    logic [31:0] rsp_rdata, rel_rdata;
    logic [1:0]  rel_tid;
    logic [3:0]  blocked_map;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xview_fifo_cell u_xview_fifo_cell (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_view(req_view),
        .req_write(req_write), .req_wdata(req_wdata), .req_tid(req_tid),
        .rsp_valid(rsp_valid), .rsp_blocked(rsp_blocked), .rsp_rdata(rsp_rdata),
        .rel_valid(rel_valid), .rel_tid(rel_tid), .rel_rdata(rel_rdata),
        .blocked_map(blocked_map)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] vw, input logic wr,
                        input logic [31:0] d, input logic [1:0] tid);
        @(negedge clk);
        req_valid = v; req_view = vw; req_write = wr; req_wdata = d; req_tid = tid;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(1'b0, V_SYNC, 1'b0, 32'h0, 2'd0);
    endtask

    task automatic rd(input logic [1:0] vw, input string req, input logic [31:0] exp);
        step(1'b1, vw, 1'b0, 32'h0, 2'd0);
        chk(req, rsp_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] vw, input logic [31:0] d, input logic [1:0] tid);
        step(1'b1, vw, 1'b1, d, tid);
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk("R1 map", {28'b0, blocked_map}, 32'h0);
        rd(V_CTRL, "R1 R9 reset tag", 32'h5);
    endtask

    task automatic t_order();
        for (int i = 0; i < 4; i++) begin
            wr(V_SYNC, 32'hA0 + i, 2'd0);
            chk("R2 push not blocked", {31'b0, rsp_blocked}, 32'h0);
        end
        rd(V_CTRL, "R12 R9 full tag", 32'h6);
        for (int i = 0; i < 4; i++) rd(V_SYNC, "R2 oldest first", 32'hA0 + i);
        rd(V_CTRL, "R12 empty tag", 32'h5);
    endtask

    task automatic t_try();
        rd(V_TRY, "R6 try read empty", 32'h0);
        chk("R6 no park", {31'b0, rsp_blocked}, 32'h0);
        for (int i = 0; i < 4; i++) wr(V_TRY, 32'hB0 + i, 2'd1);
        wr(V_TRY, 32'hBAD, 2'd1);
        chk("R6 try write full not parked", {31'b0, rsp_blocked}, 32'h0);
        chk("R6 map", {28'b0, blocked_map}, 32'h0);
        for (int i = 0; i < 4; i++) rd(V_TRY, "R6 R2 try order", 32'hB0 + i);
        rd(V_TRY, "R6 dropped write absent", 32'h0);
    endtask

    task automatic t_park_pop();
        step(1'b1, V_SYNC, 1'b0, 32'h0, 2'd2);
        chk("R3 load parked", {31'b0, rsp_blocked}, 32'h1);
        chk("R3 map bit2", {28'b0, blocked_map}, 32'h4);
        wr(V_TRY, 32'h11, 2'd3);
        chk("R4 not yet released", {31'b0, rel_valid}, 32'h0);
        idle();
        chk("R4 release valid", {31'b0, rel_valid}, 32'h1);
        chk("R4 release tid", {30'b0, rel_tid}, 32'h2);
        chk("R4 release data", rel_rdata, 32'h11);
        chk("R4 map cleared", {28'b0, blocked_map}, 32'h0);
        rd(V_CTRL, "R4 empty after release", 32'h5);
    endtask

    task automatic t_park_push();
        for (int i = 0; i < 4; i++) wr(V_SYNC, 32'hC0 + i, 2'd0);
        wr(V_SYNC, 32'hC9, 2'd1);
        chk("R3 store parked", {31'b0, rsp_blocked}, 32'h1);
        chk("R3 map bit1", {28'b0, blocked_map}, 32'h2);
        wr(V_TRY, 32'hDD, 2'd0);
        chk("R6 try full dropped", {31'b0, rsp_blocked}, 32'h0);
        rd(V_SYNC, "R2 pop while parked", 32'hC0);
        chk("R4 no release same cycle", {31'b0, rel_valid}, 32'h0);
        idle();
        chk("R4 store release valid", {31'b0, rel_valid}, 32'h1);
        chk("R4 store release tid", {30'b0, rel_tid}, 32'h1);
        chk("R4 store release data", rel_rdata, 32'h0);
        chk("R4 store map cleared", {28'b0, blocked_map}, 32'h0);
        for (int i = 1; i < 4; i++) rd(V_SYNC, "R2 remaining", 32'hC0 + i);
        rd(V_SYNC, "R4 parked store data", 32'hC9);
        rd(V_TRY, "R6 dropped absent", 32'h0);
    endtask

    task automatic t_priority();
        step(1'b1, V_SYNC, 1'b0, 32'h0, 2'd3);
        step(1'b1, V_SYNC, 1'b0, 32'h0, 2'd1);
        chk("R5 two parked", {28'b0, blocked_map}, 32'hA);
        wr(V_SYNC, 32'h21, 2'd0);
        idle();
        chk("R5 lowest first tid", {30'b0, rel_tid}, 32'h1);
        chk("R5 lowest first data", rel_rdata, 32'h21);
        chk("R5 one at a time", {28'b0, blocked_map}, 32'h8);
        wr(V_SYNC, 32'h22, 2'd0);
        idle();
        chk("R5 second tid", {30'b0, rel_tid}, 32'h3);
        chk("R5 second data", rel_rdata, 32'h22);
        chk("R5 map clear", {28'b0, blocked_map}, 32'h0);
    endtask

    task automatic t_concurrent();
        step(1'b1, V_SYNC, 1'b0, 32'h0, 2'd2);
        wr(V_SYNC, 32'h31, 2'd3);
        wr(V_SYNC, 32'h32, 2'd0);
        chk("R11 release with push", {31'b0, rel_valid}, 32'h1);
        chk("R11 release tid", {30'b0, rel_tid}, 32'h2);
        chk("R11 release data", rel_rdata, 32'h31);
        rd(V_CTRL, "R11 count kept tag", 32'h4);
        rd(V_BYP, "R11 new entry at head", 32'h32);
        rd(V_SYNC, "R11 single entry", 32'h32);
        rd(V_CTRL, "R11 empty after", 32'h5);
    endtask

    task automatic t_bypass();
        rd(V_BYP, "R7 bypass read empty", 32'h0);
        wr(V_BYP, 32'h99, 2'd0);
        rd(V_CTRL, "R8 bypass write empty dropped", 32'h5);
        wr(V_SYNC, 32'h41, 2'd0);
        wr(V_SYNC, 32'h42, 2'd0);
        rd(V_BYP, "R7 peek oldest", 32'h41);
        rd(V_BYP, "R7 peek no pop", 32'h41);
        wr(V_BYP, 32'h43, 2'd0);
        rd(V_CTRL, "R8 occupancy kept", 32'h4);
        rd(V_SYNC, "R8 oldest untouched", 32'h41);
        rd(V_SYNC, "R8 newest replaced", 32'h43);
        rd(V_TRY, "R8 no extra entry", 32'h0);
    endtask

    task automatic t_control();
        wr(V_SYNC, 32'h51, 2'd0);
        wr(V_SYNC, 32'h52, 2'd0);
        wr(V_CTRL, 32'h2, 2'd0);
        rd(V_CTRL, "R10 full bit write ignored", 32'h4);
        wr(V_CTRL, 32'h0, 2'd0);
        rd(V_CTRL, "R10 R9 kind bit stays", 32'h4);
        wr(V_CTRL, 32'h1, 2'd0);
        rd(V_CTRL, "R10 flush empties", 32'h5);
        rd(V_TRY, "R10 nothing left", 32'h0);
        wr(V_SYNC, 32'h53, 2'd0);
        rd(V_SYNC, "R10 usable after flush", 32'h53);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_order();
        t_try();
        t_park_pop();
        t_park_push();
        t_priority();
        t_concurrent();
        t_bypass();
        t_control();
        idle();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule